// File: doc/BRIEF.md
# Write-only I2C register slave with commit on STOP

This block is a receive-only I2C target for a bank of byte-wide control registers. A fast system clock samples SCL and SDA. Each line passes a two-flop synchronizer and a three-sample majority vote, and START, STOP and SCL edges are then derived from the filtered lines. After a START the block takes an address byte. When that byte names this device with the write direction, the block acknowledges it. It then takes any number of register-select/data byte pairs and acknowledges each byte by holding SDA low through the ninth clock.

Every data byte lands in a staging latch for its register. The parallel outputs never move while a transfer is in progress. They are loaded from the staging latches, all at once, only when a STOP is honoured. A pending flag records staged data that has not yet been committed. A lock flag records that this device has been selected and owes a complete select/data pair. A STOP commits only when data is pending and the lock is clear. With this rule an interrupted pair cannot commit. A STOP that ends another target's transfer can still commit data staged earlier.

The receiver states are ST_IDLE (bus free), ST_ADDR (shifting the address byte), ST_ADDR_ACK, ST_SUB (shifting the register select), ST_SUB_ACK, ST_DATA (shifting data), ST_DATA_ACK and ST_SKIP (not selected, waiting for a START). The transitions are:
- A START from any state leads to ST_ADDR. A STOP from any state leads to ST_IDLE.
- In ST_ADDR, the SCL fall that ends the eighth bit leads to ST_ADDR_ACK on a match and to ST_SKIP otherwise.
- ST_SUB moves to ST_SUB_ACK, and ST_DATA moves to ST_DATA_ACK, on that same kind of eighth-bit fall.
- Each acknowledge state moves on at the falling SCL of the ninth clock. ST_ADDR_ACK and ST_DATA_ACK go to ST_SUB, and ST_SUB_ACK goes to ST_DATA.

Top module: `i2c_wo_commit`

## Requirements
- R1: An address byte of 0x36 (device address 0011011 with the direction bit 0), sent MSB first, is acknowledged.
- R2: Any other address byte, including 0x37 (direction bit 1), is not acknowledged. SDA then stays released for every following byte until the next START.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Both are recognised in every receiver state, and back-to-back transactions each commit correctly.
- R4: On each acknowledged byte, SDA is pulled low before SCL rises for the ninth clock and stays low for that whole SCL high period. The pull is released after SCL falls.
- R5: The register outputs are unchanged while bytes are received. They take the staged values only on an honoured STOP.
- R6: A STOP that follows an acknowledged address or register-select byte, before the data byte of the pair is acknowledged, commits nothing. Later STOPs also commit nothing until this device has again received a full select/data pair.
- R7: Staged data that is not yet committed is committed by the next STOP on the bus, even after repeated STARTs that address other devices.
- R8: After a repeated START re-addresses this device and the address is acknowledged, a STOP commits nothing until a new select/data pair has been acknowledged.
- R9: A register select of 16 or more is acknowledged, and so is its data byte, but no register changes. Selects 0 to 15 choose the register directly, and register n sits at reg_out bits [8n+7:8n].
- R10: A pulse on SCL or SDA lasting one system clock is ignored. It creates no bit, no START and no STOP.
- R11: A synchronous active-high reset clears all staging latches, outputs and the pending flag, and releases SDA. A STOP after reset commits nothing.
- R12: Several select/data pairs in one transaction each stage their byte, and one STOP commits all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled I2C clock line |
| sda_in | input | 1 | Sampled I2C data line (wired-AND bus level) |
| sda_pull | output | 1 | 1 drives SDA low (acknowledge) |
| reg_out | output | NUM_REGS*8 | Committed register bank, register n at bits [8n+7:8n] |

## Verification
The hardest situation to reach is a STOP whose effect depends on earlier history, so that the same STOP commits in one case and not in another. The three histories are:
- a pair left unfinished, where the lock persists across a foreign transaction;
- a repeated START that re-selects this device after data was staged;
- staged data followed by repeated STARTs to other addresses.

The stimulus builds each history explicitly and compares the whole register bank before and after each STOP. Single-clock spikes are injected inside real bit periods. Each spike would cause a false START, a false STOP or an extra clock if it were accepted. Any of these loses the following acknowledge or corrupts the committed byte.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2cw_glitch_filter.sv
module i2cw_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_out
);

    localparam int MAJORITY = VOTE_TAPS / 2 + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   tap_q;
    logic                   out_q;
    logic                   vote;

    always_comb begin
        int ones;
        ones = 0;
        for (int k = 0; k < VOTE_TAPS; k++) begin
            ones = ones + int'(tap_q[k]);
        end
        vote = (ones >= MAJORITY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            tap_q  <= '1;
            out_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            tap_q  <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            out_q  <= vote;
        end
    end

    assign line_out = out_q;

endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.start    = scl_f & scl_p & sda_p & ~sda_f;
        ev.stop     = scl_f & scl_p & ~sda_p & sda_f;
        ev.scl_rise = scl_f & ~scl_p;
        ev.scl_fall = ~scl_f & scl_p;
        ev.sda      = sda_f;
    end

endmodule

// File: rtl/i2cw_rx_fsm.sv
module i2cw_rx_fsm
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1B,
    parameter int         NUM_REGS = 16,
    localparam int        IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit
);

    localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

    rx_state_e         state, state_n;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] sub_q;
    logic [3:0]        bitcnt;
    logic              lock;
    logic              pending;
    logic              byte_done;
    logic              addr_ok;
    logic              sub_in_range;
    logic              shifting;

    assign byte_done    = ev.scl_fall && (bitcnt == 4'd8);
    assign addr_ok      = (shreg == ADDR_BYTE);
    assign sub_in_range = ((sub_q >> IDX_W) == '0);
    assign shifting     = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);

    // next-state decode
    always_comb begin
        state_n = state;
        if (ev.start) begin
            state_n = ST_ADDR;
        end else if (ev.stop) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_SKIP:     state_n = ST_SKIP;
                ST_ADDR:     if (byte_done) state_n = addr_ok ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (ev.scl_fall) state_n = ST_SUB;
                ST_SUB:      if (byte_done) state_n = ST_SUB_ACK;
                ST_SUB_ACK:  if (ev.scl_fall) state_n = ST_DATA;
                ST_DATA:     if (byte_done) state_n = ST_DATA_ACK;
                ST_DATA_ACK: if (ev.scl_fall) state_n = ST_SUB;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            sub_q    <= '0;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            lock     <= 1'b0;
            pending  <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            commit   <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            commit <= 1'b0;
            if (ev.start) begin
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                if (pending && !lock) begin
                    commit  <= 1'b1;
                    pending <= 1'b0;
                end
            end else begin
                if (ev.scl_rise && shifting && (bitcnt < 4'd8)) begin
                    shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                    bitcnt <= bitcnt + 4'd1;
                end
                if (ev.scl_fall) begin
                    unique case (state)
                        ST_ADDR: begin
                            if (byte_done) begin
                                bitcnt <= '0;
                                if (addr_ok) begin
                                    sda_pull <= 1'b1;
                                    lock     <= 1'b1;
                                end
                            end
                        end
                        ST_SUB: begin
                            if (byte_done) begin
                                bitcnt   <= '0;
                                sda_pull <= 1'b1;
                                lock     <= 1'b1;
                                sub_q    <= shreg;
                            end
                        end
                        ST_DATA: begin
                            if (byte_done) begin
                                bitcnt   <= '0;
                                sda_pull <= 1'b1;
                                lock     <= 1'b0;
                                if (sub_in_range) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= sub_q[IDX_W-1:0];
                                    wr_data <= shreg;
                                    pending <= 1'b1;
                                end
                            end
                        end
                        ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: begin
                            sda_pull <= 1'b0;
                        end
                        ST_IDLE, ST_SKIP: begin
                            sda_pull <= 1'b0;
                        end
                        default: sda_pull <= 1'b0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/i2cw_reg_bank.sv
module i2cw_reg_bank #(
    parameter int  NUM_REGS = 16,
    parameter int  DATA_W   = 8,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         commit,
    output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] hold_q;
        logic [DATA_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
                out_q  <= '0;
            end else begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    hold_q <= wr_data;
                end
                if (commit) begin
                    out_q <= hold_q;
                end
            end
        end

        assign regs_flat[i*DATA_W +: DATA_W] = out_q;
    end

endmodule

// File: rtl/i2c_wo_commit.sv
module i2c_wo_commit
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h1B,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2,
    parameter int         VOTE_TAPS   = 3,
    localparam int        IDX_W       = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_pull,
    output logic [NUM_REGS*BYTE_W-1:0] reg_out
);

    logic [1:0]        line_raw;
    logic [1:0]        line_f;
    logic              scl_f;
    logic              sda_f;
    bus_ev_t           ev;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic              commit_pulse;

    assign line_raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2cw_glitch_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .VOTE_TAPS   (VOTE_TAPS)
        ) u_filt (
            .clk      (clk),
            .rst      (rst),
            .line_in  (line_raw[g]),
            .line_out (line_f[g])
        );
    end

    assign scl_f = line_f[0];
    assign sda_f = line_f[1];

    i2cw_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .ev    (ev)
    );

    i2cw_rx_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .commit   (commit_pulse)
    );

    i2cw_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (BYTE_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .commit    (commit_pulse),
        .regs_flat (reg_out)
    );

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
    parameter int OUT_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_f,
    input logic             sda_pull,
    input logic             commit,
    input logic [OUT_W-1:0] reg_out
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d === 1'b1) begin
            a_r11_reset_clear: assert (sda_pull == 1'b0 && reg_out == '0)
                else $error("R11: state not cleared by reset");
        end
    end

    a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(reg_out))
        else $error("R5: outputs moved without a commit");

    a_r4_pull_steady_high: assert property (@(posedge clk) disable iff (rst)
        (scl_f && $past(scl_f)) |-> $stable(sda_pull))
        else $error("R4: SDA pull changed while SCL high");

    a_r4_pull_rise_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_f)
        else $error("R4: SDA pull started while SCL high");

    a_r7_commit_single: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit)
        else $error("R7: commit longer than one cycle");

    a_r3_commit_released: assert property (@(posedge clk) disable iff (rst)
        commit |-> !sda_pull)
        else $error("R3: commit while acknowledging");

endmodule

bind i2c_wo_commit i2cw_checker #(.OUT_W(NUM_REGS*8)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_pull (sda_pull),
    .commit   (commit_pulse),
    .reg_out  (reg_out)
);

// File: tb/i2c_wo_commit_bench.sv
module i2c_wo_commit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 10;
    localparam int NREG       = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_pull;
    logic [NREG*8-1:0] reg_out;
    logic sda_line;

    assign sda_line = sda_drv & ~sda_pull;

    i2c_wo_commit u_i2c_wo_commit (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_drv),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .reg_out  (reg_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_out [NREG];
    logic [7:0] holdv [NREG];
    bit ack, steady;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        int first;
        first = -1;
        total++;
        for (int i = 0; i < NREG; i++) begin
            if (first < 0 && reg_out[i*8 +: 8] !== exp_out[i]) first = i;
        end
        if (first >= 0) begin
            bad++;
            $display("FAIL %s reg%0d act=%0h exp=%0h", tag, first,
                     reg_out[first*8 +: 8], exp_out[first]);
        end
    endtask

    task automatic bus_start();
        if (scl_drv == 1'b0) begin
            sda_drv = 1'b1; wait_clk(H);
            scl_drv = 1'b1; wait_clk(H);
        end
        sda_drv = 1'b0; wait_clk(H);
        scl_drv = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_clk(H);
        scl_drv = 1'b1; wait_clk(H);
        sda_drv = 1'b1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch,
                             output bit got_ack, output bit held);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i];
            wait_clk(H/2);
            if (glitch) begin
                scl_drv = 1'b1; wait_clk(1); scl_drv = 1'b0;
            end
            wait_clk(H/2);
            scl_drv = 1'b1;
            wait_clk(H/2);
            if (glitch) begin
                sda_drv = ~b[i]; wait_clk(1); sda_drv = b[i];
            end
            wait_clk(H/2);
            scl_drv = 1'b0;
        end
        sda_drv = 1'b1;
        wait_clk(H);
        scl_drv = 1'b1;
        wait_clk(1);
        a1 = ~sda_line;
        wait_clk(H-2);
        a2 = ~sda_line;
        wait_clk(1);
        scl_drv = 1'b0;
        got_ack = a1;
        held = a1 & a2;
    endtask

    task automatic pair(input logic [7:0] sub, input logic [7:0] dat, input string tag);
        bit a, s;
        send_byte(sub, 1'b0, a, s);
        chk({tag, " sub ack"}, int'(a), 1);
        send_byte(dat, 1'b0, a, s);
        chk({tag, " data ack"}, int'(a), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NREG; i++) exp_out[i] = 8'h00;
        rst = 1'b1;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R11: reset state
        check_bank("R11 reset bank");
        chk("R11 sda released", int'(sda_line), 1);

        // R2: read direction and foreign address are not acknowledged
        bus_start();
        send_byte(8'h37, 1'b0, ack, steady);
        chk("R2 rw=1 nack", int'(ack), 0);
        send_byte(8'h03, 1'b0, ack, steady);
        chk("R2 idle after nack", int'(ack), 0);
        send_byte(8'h44, 1'b0, ack, steady);
        chk("R2 still idle", int'(ack), 0);
        bus_stop();
        check_bank("R2 bank unchanged");
        bus_start();
        send_byte(8'h50, 1'b0, ack, steady);
        chk("R2 other address nack", int'(ack), 0);
        bus_stop();

        // R1, R4, R5: single write
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        chk("R1 address ack", int'(ack), 1);
        chk("R4 ack held whole high", int'(steady), 1);
        pair(8'h03, 8'hA5, "R5");
        check_bank("R5 no change before stop");
        bus_stop();
        exp_out[3] = 8'hA5;
        check_bank("R5 commit on stop");

        // R12: several pairs in one transaction
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        pair(8'h01, 8'h11, "R12");
        pair(8'h02, 8'h22, "R12");
        bus_stop();
        exp_out[1] = 8'h11;
        exp_out[2] = 8'h22;
        check_bank("R12 both committed");

        // R6: stop after select only is ignored, lock persists
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        send_byte(8'h05, 1'b0, ack, steady);
        bus_stop();
        check_bank("R6 early stop ignored");
        bus_start();
        send_byte(8'h50, 1'b0, ack, steady);
        bus_stop();
        check_bank("R6 foreign stop ignored");
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        pair(8'h06, 8'h66, "R6");
        bus_stop();
        exp_out[6] = 8'h66;
        check_bank("R6 full pair commits");

        // R7: pending data committed by stop after foreign repeated starts
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        pair(8'h07, 8'h77, "R7");
        bus_start();
        send_byte(8'h50, 1'b0, ack, steady);
        chk("R7 foreign nack", int'(ack), 0);
        send_byte(8'h12, 1'b0, ack, steady);
        bus_start();
        send_byte(8'h52, 1'b0, ack, steady);
        check_bank("R7 held before stop");
        bus_stop();
        exp_out[7] = 8'h77;
        check_bank("R7 foreign stop commits");

        // R8: re-addressed by repeated start, stop ignored
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        pair(8'h08, 8'h88, "R8");
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        chk("R8 readdress ack", int'(ack), 1);
        bus_stop();
        check_bank("R8 stop ignored");
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        pair(8'h09, 8'h99, "R8");
        bus_stop();
        exp_out[8] = 8'h88;
        exp_out[9] = 8'h99;
        check_bank("R8 later commit");

        // R9: out-of-range select acknowledged and discarded
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        pair(8'h13, 8'h5A, "R9");
        pair(8'hF3, 8'hC6, "R9");
        bus_stop();
        check_bank("R9 bank unchanged");

        // R10: single-clock spikes on both lines
        bus_start();
        send_byte(8'h36, 1'b1, ack, steady);
        chk("R10 address with spikes", int'(ack), 1);
        send_byte(8'h0A, 1'b1, ack, steady);
        chk("R10 select with spikes", int'(ack), 1);
        send_byte(8'hC3, 1'b1, ack, steady);
        chk("R10 data with spikes", int'(ack), 1);
        bus_stop();
        exp_out[10] = 8'hC3;
        check_bank("R10 data intact");

        // R11: reset mid-way clears pending data
        bus_start();
        send_byte(8'h36, 1'b0, ack, steady);
        pair(8'h02, 8'hEE, "R11");
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(3);
        for (int i = 0; i < NREG; i++) exp_out[i] = 8'h00;
        check_bank("R11 bank cleared");
        chk("R11 pull released", int'(sda_pull), 0);
        bus_stop();
        check_bank("R11 no commit after reset");

        // R3: random transactions
        for (int i = 0; i < NREG; i++) holdv[i] = exp_out[i];
        for (int t = 0; t < 24; t++) begin
            int np;
            np = 1 + int'($urandom % 3);
            bus_start();
            send_byte(8'h36, 1'b0, ack, steady);
            chk("R3 random address ack", int'(ack), 1);
            for (int p = 0; p < np; p++) begin
                logic [7:0] s, d;
                s = 8'($urandom % 20);
                d = 8'($urandom);
                pair(s, d, "R3");
                if (s < 8'd16) holdv[s[3:0]] = d;
            end
            check_bank("R5 random before stop");
            if (($urandom % 4) == 0) begin
                bus_start();
                send_byte(8'h50, 1'b0, ack, steady);
            end
            bus_stop();
            for (int i = 0; i < NREG; i++) exp_out[i] = holdv[i];
            check_bank("R3 random commit");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule